// File: doc/BRIEF.md
# Next-PC and Branch Target Generator

This block picks the address of the next instruction for a processor whose instructions are 32 bits wide and whose memory is byte addressed. Each transaction carries the current PC, the instruction's 16-bit offset and 26-bit jump field, a register value for register jumps, two register operands for equality tests, a floating-point condition flag and a decoded control-flow kind. The block tests the branch condition and chooses one of four target modes: sequential, PC-relative, region jump within the current 256 MiB window, or register-indirect. It returns the next PC and, for a call, the return address to write to the link register.

Transactions enter on a valid/ready stream and leave on a registered valid/ready stream, one result per accepted input, in order. An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` passes back to the input with no added delay. While `out_valid` is high and `out_ready` is low, the output holds every field steady.

Top module: `npc_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Kind code 0 (sequential) gives next PC = PC+4, wrapping modulo 2^32, with `out_link_we` = 0.
- R3: Kind code 1 (branch on equal) gives PC+4 + (sign-extended offset × 4) when the operands are equal, and PC+4 otherwise.
- R4: Kind code 2 (branch on not equal) gives the same relative target when the operands differ, and PC+4 otherwise.
- R5: Kind code 3 branches to the relative target when the floating-point flag is 1, and kind code 4 when it is 0. Otherwise both give PC+4.
- R6: Kind code 5 (region jump) gives {PC+4 bits 31..28, jump field, 2'b00}, so the top bits come from PC+4 and not from PC.
- R7: Kind code 6 (call) gives the same target as R6 with `out_link_we` = 1 and `out_link` = PC+4. Every other kind gives `out_link_we` = 0.
- R8: Kind code 7 (register jump) gives next PC = the register value, unchanged.
- R9: Kind codes 8 to 15 are treated as sequential: PC+4 with `out_link_we` = 0.
- R10: While `out_valid` = 1 and `out_ready` = 0, all outputs stay stable. Results leave in acceptance order, one for each accepted input.
- R11: A result is valid on the output in the cycle after its input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_pc | input | 32 | Current PC |
| in_imm | input | 16 | Branch offset in words, two's complement |
| in_jfield | input | 26 | Region-jump word index |
| in_rjump | input | 32 | Register value for a register jump |
| in_opa | input | 32 | First compare operand |
| in_opb | input | 32 | Second compare operand |
| in_fpcc | input | 1 | Floating-point condition flag |
| in_kind | input | 4 | Control-flow kind code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_npc | output | 32 | Next PC |
| out_link_we | output | 1 | Write the link register |
| out_link | output | 32 | Return address (PC+4) |

## Verification
The hardest case to reach is a result that stalls under back-pressure while the next input waits: the output must not change, and the waiting input must not overwrite it. The bench gets there by turning `out_ready` low in a pseudo-random pattern during a long burst of back-to-back inputs. The burst covers every kind code and operand values that make each condition true or false. Region jumps are also issued from the last word of a 256 MiB window, so PC+4 crosses into the next window and the top bits of PC and PC+4 differ.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_SEQ  = 4'd0,
    K_BEQ  = 4'd1,
    K_BNE  = 4'd2,
    K_FPT  = 4'd3,
    K_FPF  = 4'd4,
    K_JMP  = 4'd5,
    K_CALL = 4'd6,
    K_JREG = 4'd7
  } flow_kind_e;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_REL    = 2'd1,
    SEL_REGION = 2'd2,
    SEL_REG    = 2'd3
  } tgt_sel_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              fpcc,
  output logic              take
);
  logic same;
  assign same = (opa == opb);

  always_comb begin
    case (flow_kind_e'(kind))
      K_BEQ:   take = same;
      K_BNE:   take = !same;
      K_FPT:   take = fpcc;
      K_FPF:   take = !fpcc;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_sel_decode.sv
module npc_sel_decode
  import npc_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              take,
  output tgt_sel_e          sel,
  output logic              link_we
);
  always_comb begin
    link_we = 1'b0;
    case (flow_kind_e'(kind))
      K_BEQ, K_BNE, K_FPT, K_FPF: sel = take ? SEL_REL : SEL_SEQ;
      K_JMP:                      sel = SEL_REGION;
      K_CALL: begin
        sel     = SEL_REGION;
        link_we = 1'b1;
      end
      K_JREG:                     sel = SEL_REG;
      default:                    sel = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int JF_W   = 26,
  parameter int ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JF_W-1:0]   jfield,
  input  logic [ADDR_W-1:0] rjump,
  input  tgt_sel_e          sel,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] link
);
  localparam int EXT_W    = ADDR_W - IMM_W - ALIGN;
  localparam int REGION_W = ADDR_W - JF_W - ALIGN;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] rel_off;
  logic [ADDR_W-1:0] rel_pc;
  logic [ADDR_W-1:0] region_pc;

  assign seq_pc  = pc + STEP;
  assign rel_off = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN{1'b0}}};
  assign rel_pc  = seq_pc + rel_off;

  generate
    if (REGION_W > 0) begin : g_region
      assign region_pc = {seq_pc[ADDR_W-1 -: REGION_W], jfield, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign region_pc = ADDR_W'({jfield, {ALIGN{1'b0}}});
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_REL:    npc = rel_pc;
      SEL_REGION: npc = region_pc;
      SEL_REG:    npc = rjump;
      default:    npc = seq_pc;
    endcase
  end

  assign link = seq_pc;
endmodule

// File: rtl/npc_out_reg.sv
module npc_out_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] d_npc,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_link,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_npc,
  output logic              out_link_we,
  output logic [ADDR_W-1:0] out_link
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_npc     <= '0;
      out_link_we <= 1'b0;
      out_link    <= '0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_npc     <= d_npc;
      out_link_we <= d_we;
      out_link    <= d_link;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int JF_W   = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_pc,
  input  logic [IMM_W-1:0]     in_imm,
  input  logic [JF_W-1:0]      in_jfield,
  input  logic [ADDR_W-1:0]    in_rjump,
  input  logic [ADDR_W-1:0]    in_opa,
  input  logic [ADDR_W-1:0]    in_opb,
  input  logic                 in_fpcc,
  input  logic [KIND_W-1:0]    in_kind,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_npc,
  output logic                 out_link_we,
  output logic [ADDR_W-1:0]    out_link
);
  logic              take;
  tgt_sel_e          sel;
  logic              we_c;
  logic [ADDR_W-1:0] npc_c;
  logic [ADDR_W-1:0] link_c;

  npc_cond_eval #(.DATA_W(ADDR_W)) u_cond (
    .kind(in_kind), .opa(in_opa), .opb(in_opb), .fpcc(in_fpcc), .take(take)
  );

  npc_sel_decode u_sel (
    .kind(in_kind), .take(take), .sel(sel), .link_we(we_c)
  );

  npc_target_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JF_W(JF_W), .ALIGN(2)) u_tgt (
    .pc(in_pc), .imm(in_imm), .jfield(in_jfield), .rjump(in_rjump),
    .sel(sel), .npc(npc_c), .link(link_c)
  );

  npc_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_npc(npc_c), .d_we(we_c), .d_link(link_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_npc(out_npc), .out_link_we(out_link_we), .out_link(out_link)
  );
endmodule

// File: rtl/npc_gen_chk.sv
module npc_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int KIND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_pc,
  input logic [ADDR_W-1:0] in_rjump,
  input logic [KIND_W-1:0] in_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_npc,
  input logic              out_link_we,
  input logic [ADDR_W-1:0] out_link
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == KIND_W'(0) |=> out_npc == ADDR_W'($past(in_pc) + ADDR_W'(4)));

  assert_call_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == KIND_W'(6) |=> out_link_we && out_link == ADDR_W'($past(in_pc) + ADDR_W'(4)));

  assert_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind != KIND_W'(6) |=> !out_link_we);

  assert_regjump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_kind == KIND_W'(7) |=> out_npc == $past(in_rjump));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_npc) && $stable(out_link_we) && $stable(out_link));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
endmodule

bind npc_gen npc_gen_chk #(.ADDR_W(ADDR_W), .KIND_W(npc_pkg::KIND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pc(in_pc), .in_rjump(in_rjump), .in_kind(in_kind),
  .out_valid(out_valid), .out_ready(out_ready), .out_npc(out_npc),
  .out_link_we(out_link_we), .out_link(out_link)
);

// File: tb/npc_gen_bench.sv
module npc_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0, in_rjump = '0, in_opa = '0, in_opb = '0;
  logic [15:0] in_imm = '0;
  logic [25:0] in_jfield = '0;
  logic        in_fpcc = 1'b0;
  logic [3:0]  in_kind = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_npc, out_link;
  logic        out_link_we;

  always #10 clk = ~clk;

  npc_gen u_npc_gen (.*);

  typedef struct { logic [31:0] npc; logic we; logic [31:0] link; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0, cycles = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic hold_pend = 1'b0;
  logic [31:0] h_npc, h_link;
  logic h_we;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] k, input logic [31:0] pc, input logic [15:0] imm,
                                 input logic [25:0] jf, input logic [31:0] rj,
                                 input logic [31:0] a, input logic [31:0] b, input logic fc);
    exp_t e;
    logic [31:0] p4, rel;
    p4  = pc + 32'd4;
    rel = p4 + 32'($signed(imm) * 4);
    e.we = 1'b0; e.link = p4; e.npc = p4;
    case (k)
      4'd0: e.tag = "R2";
      4'd1: begin e.tag = "R3"; if (a == b) e.npc = rel; end
      4'd2: begin e.tag = "R4"; if (a != b) e.npc = rel; end
      4'd3: begin e.tag = "R5"; if (fc) e.npc = rel; end
      4'd4: begin e.tag = "R5"; if (!fc) e.npc = rel; end
      4'd5: begin e.tag = "R6"; e.npc = {p4[31:28], jf, 2'b00}; end
      4'd6: begin e.tag = "R7"; e.npc = {p4[31:28], jf, 2'b00}; e.we = 1'b1; end
      4'd7: begin e.tag = "R8"; e.npc = rj; end
      default: e.tag = "R9";
    endcase
    return e;
  endfunction

  task automatic send(input logic [3:0] k, input logic [31:0] pc, input logic [15:0] imm,
                      input logic [25:0] jf, input logic [31:0] rj,
                      input logic [31:0] a, input logic [31:0] b, input logic fc);
    @(negedge clk);
    in_kind = k; in_pc = pc; in_imm = imm; in_jfield = jf; in_rjump = rj;
    in_opa = a; in_opb = b; in_fpcc = fc; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    sb.push_back(model(k, pc, imm, jf, rj, a, b, fc));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: sets ready for the coming edge, then checks hold and pops the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
      if (hold_pend) begin
        check(out_valid && out_npc == h_npc && out_link_we == h_we && out_link == h_link,
              "R10 hold", out_npc, h_npc);
      end
      hold_pend = out_valid && !out_ready;
      h_npc = out_npc; h_we = out_link_we; h_link = out_link;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 extra result", out_npc, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_npc == e.npc, e.tag, out_npc, e.npc);
          check(out_link_we == e.we, {e.tag, " link_we"}, {31'd0, out_link_we}, {31'd0, e.we});
          if (e.we) check(out_link == e.link, {e.tag, " link"}, out_link, e.link);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 in reset", {30'd0, out_valid, in_ready}, 32'd1);
    @(negedge clk) rst_n = 1'b1;
    #1 check(!out_valid && in_ready, "R1 after reset", {30'd0, out_valid, in_ready}, 32'd1);

    // R2 sequential, including wrap
    send(4'd0, 32'h0040_0000, 16'd0, 26'd0, 32'd0, 32'd0, 32'd0, 1'b0);
    send(4'd0, 32'hFFFF_FFFC, 16'd5, 26'd9, 32'd1, 32'd0, 32'd0, 1'b1);
    // R3: offset 25 moves 100 bytes past PC+4
    send(4'd1, 32'h0040_0000, 16'd25, 26'd0, 32'd0, 32'd7, 32'd7, 1'b0);
    send(4'd1, 32'h0040_0000, 16'd25, 26'd0, 32'd0, 32'd7, 32'd8, 1'b0);
    send(4'd1, 32'h0040_0100, 16'hFFFF, 26'd0, 32'd0, 32'd3, 32'd3, 1'b0);
    send(4'd1, 32'h0040_0000, 16'h8000, 26'd0, 32'd0, 32'd0, 32'd0, 1'b0);
    // R4
    send(4'd2, 32'h0001_0000, 16'd25, 26'd0, 32'd0, 32'd1, 32'd2, 1'b0);
    send(4'd2, 32'h0001_0000, 16'd25, 26'd0, 32'd0, 32'd5, 32'd5, 1'b0);
    // R5
    send(4'd3, 32'h0002_0000, 16'd12, 26'd0, 32'd0, 32'd0, 32'd1, 1'b1);
    send(4'd3, 32'h0002_0000, 16'd12, 26'd0, 32'd0, 32'd0, 32'd0, 1'b0);
    send(4'd4, 32'h0002_0000, 16'hFFF0, 26'd0, 32'd0, 32'd0, 32'd0, 1'b0);
    send(4'd4, 32'h0002_0000, 16'hFFF0, 26'd0, 32'd0, 32'd0, 32'd0, 1'b1);
    // R6: field 2500 -> 10000, and window crossing
    send(4'd5, 32'h0000_0000, 16'd0, 26'd2500, 32'd0, 32'd0, 32'd0, 1'b0);
    send(4'd5, 32'h0FFF_FFFC, 16'd0, 26'h3FF_FFFF, 32'd0, 32'd0, 32'd0, 1'b0);
    // R7
    send(4'd6, 32'h0040_1234, 16'd0, 26'd2500, 32'd0, 32'd1, 32'd1, 1'b0);
    // R8
    send(4'd7, 32'h0040_0000, 16'd3, 26'd3, 32'h8000_0003, 32'd0, 32'd0, 1'b0);
    // R9
    send(4'd8, 32'h0000_1000, 16'd25, 26'd2500, 32'd4, 32'd1, 32'd1, 1'b1);
    send(4'd15, 32'h0000_2000, 16'd25, 26'd2500, 32'd4, 32'd1, 32'd1, 1'b0);

    // R10/R11: back-to-back burst under pseudo-random back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = 32'h9E37_79B9 * (i + 1);
      send(4'(i), {r[31:2], 2'b00}, r[17:2], r[27:2], r ^ 32'h55AA_33CC,
           32'(i % 3), 32'(i % 2), r[5]);
    end
    bp_on = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!out_valid, "R10 drained", {31'd0, out_valid}, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule